// File: doc/BRIEF.md
# Passive-Matrix LCD Refresh Controller

This block keeps a monochrome graphic LCD refreshed when the panel carries only row and column drivers and has no controller of its own. It holds the image in an internal frame buffer of 4-bit words and reads that buffer row by row. Each word leaves on a 4-bit data bus, four pixels at a time, under a shift clock. A row-latch pulse closes every row. A frame marker accompanies the latch of the first row, and an AC-polarity line inverts once per frame so the liquid crystal never sees a DC bias. A drive-enable output gates the panel's bias supply. It stays low until the polarity line has been seen to invert a set number of times.

A host loads the frame buffer through a one-word synchronous write port. The display has one buffer read per shift-clock period, and that read wins the single RAM port. In that cycle the port raises a busy flag, and the host holds its request for one more cycle. Panel width, height, the system-clock divider and the number of polarity inversions that arm the drive enable are parameters.

The sequencer is a four-state machine, and the divider tick advances it:
- `ST_SHIFT_LO`: shift clock low. The next word is fetched in the first cycle of this state.
- `ST_SHIFT_HI`: shift clock high.
- `ST_LATCH`: row latch high.
- `ST_HOLD`: row latch low again, with the frame marker still held.

The transitions are named as follows:
- T_RISE: `ST_SHIFT_LO`→`ST_SHIFT_HI`. It loads the fetched word onto the bus.
- T_NEXT_COL: `ST_SHIFT_HI`→`ST_SHIFT_LO`, taken when the row has more columns.
- T_ROW_END: `ST_SHIFT_HI`→`ST_LATCH`, taken after the last column.
- T_LATCH_DROP: `ST_LATCH`→`ST_HOLD`.
- T_NEXT_ROW: `ST_HOLD`→`ST_SHIFT_LO`.

Top module: `lcd_refresh_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `lcd_shift_clk`, `lcd_row_latch`, `lcd_frame_mark`, `lcd_polarity`, `lcd_drive_en` and `lcd_data` are all 0.
- R2: `lcd_data` changes only on a rising transition of `lcd_shift_clk`. It holds its value across every falling transition, which is where the panel samples it.
- R3: Each row has WIDTH/4 shift-clock pulses, then exactly one row-latch pulse. Every phase of each pulse lasts CLK_DIV system cycles, so successive row-latch rises are (2·WIDTH/4+2)·CLK_DIV cycles apart.
- R4: `lcd_shift_clk` stays low whenever `lcd_row_latch` is high.
- R5: `lcd_frame_mark` rises together with the row latch that closes row 0. It stays high across that latch's falling edge and is low for every other row. Consecutive frame marks are therefore HEIGHT row periods apart.
- R6: `lcd_polarity` inverts exactly once per frame, in the same cycle that `lcd_frame_mark` rises, and at no other time.
- R7: `lcd_drive_en` stays 0 until `lcd_polarity` has inverted ARM_TOGGLES times since reset. It is 1 from the second cycle after that inversion onward.
- R8: Word address r·(WIDTH/4)+c of the buffer appears unchanged, bit for bit, on `lcd_data` during shift pulse c (counting from 0) of row r. After row HEIGHT−1 the reading restarts at address 0, and buffer contents survive reset.
- R9: `host_wr_busy` is high for exactly one cycle per shift-clock period, in the first cycle of the low phase. A write is committed only in a cycle with `host_wr_en` high and `host_wr_busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write request; held until accepted |
| host_wr_addr | input | AW | Word address, row-major, WIDTH/4 words per row |
| host_wr_data | input | 4 | Four pixels for the addressed word |
| host_wr_busy | output | 1 | Display read owns the RAM this cycle; write not taken |
| lcd_data | output | 4 | Pixel nibble to the column drivers |
| lcd_shift_clk | output | 1 | Column shift clock; panel samples on its falling edge |
| lcd_row_latch | output | 1 | Row latch pulse closing each row |
| lcd_frame_mark | output | 1 | First-row marker |
| lcd_polarity | output | 1 | AC drive polarity, inverted once per frame |
| lcd_drive_en | output | 1 | Enable for the panel bias supply |

## Verification
The hardest state to reach from the ports is a host write landing exactly in the one-cycle window where the display read owns the RAM, while the frame image stays coherent. The stimulus loads the whole buffer with back-to-back writes while refresh runs. These writes always cover several fetch cycles, so some are stalled and retried. The bench then captures two complete frames off the panel pins and compares each nibble with the pattern. A reset in the middle of a run then checks that the polarity arming restarts from zero and that the read address restarts at word 0 over buffer contents kept through the reset.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

    // One-hot so every panel strobe maps onto one flop bit of the state.
    typedef enum logic [3:0] {
        ST_SHIFT_LO = 4'b0001,
        ST_SHIFT_HI = 4'b0010,
        ST_LATCH    = 4'b0100,
        ST_HOLD     = 4'b1000
    } lcd_state_e;

    function automatic int safe_clog2(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lcdt_tick.sv
module lcdt_tick #(
    parameter int DIV = 25,
    localparam int CW = lcdt_pkg::safe_clog2(DIV)
) (
    input  logic clk,
    input  logic rst,
    output logic tick,
    output logic phase0
);

    logic [CW-1:0] cnt_q;

    assign tick   = (cnt_q == CW'(DIV - 1));
    assign phase0 = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R3: the divider never runs past its terminal count
    p_div_range_r3: assert property (@(posedge clk) disable iff (rst)
        tick |=> phase0);

endmodule

// File: rtl/lcdt_fb.sv
module lcdt_fb #(
    parameter int DEPTH = 512,
    localparam int AW = lcdt_pkg::safe_clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [3:0]    rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [3:0]    wr_data
);

    logic [3:0] mem [DEPTH];
    logic       wr_ok;

    // Display read has priority over the host on the single port.
    assign wr_ok = wr_en && !rd_en && (32'(wr_addr) < DEPTH);

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem[rd_addr];
        end else if (wr_ok) begin
            mem[wr_addr] <= wr_data;
        end
    end

endmodule

// File: rtl/lcdt_polguard.sv
module lcdt_polguard #(
    parameter int ARM = 2,
    localparam int NW = lcdt_pkg::safe_clog2(ARM + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic pol_in,
    output logic drive_en
);

    logic          prev_q;
    logic [NW-1:0] seen_q;
    logic          flip;

    assign flip     = pol_in ^ prev_q;
    assign drive_en = (seen_q == NW'(ARM));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            seen_q <= '0;
        end else begin
            prev_q <= pol_in;
            if (flip && !drive_en) begin
                seen_q <= seen_q + 1'b1;
            end
        end
    end

    // R7: the enable only arms right after a seen polarity inversion
    p_arm_on_flip_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_en) |-> $past(pol_in) != $past(prev_q));

    // R7: once armed it stays armed until reset
    p_arm_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        drive_en |=> drive_en);

endmodule

// File: rtl/lcdt_seq.sv
module lcdt_seq
    import lcdt_pkg::*;
#(
    parameter int NIB  = 16,
    parameter int ROWS = 32,
    localparam int WORDS = NIB * ROWS,
    localparam int AW    = safe_clog2(WORDS),
    localparam int CW    = safe_clog2(NIB),
    localparam int RW    = safe_clog2(ROWS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          phase0,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    input  logic [3:0]    rd_data,
    output logic [3:0]    pix_nib,
    output logic          shift_clk,
    output logic          row_latch,
    output logic          frame_mark,
    output logic          polarity
);

    lcd_state_e    state_q, state_d;
    logic [CW-1:0] col_q;
    logic [RW-1:0] row_q;
    logic [AW-1:0] addr_q;
    logic          last_col, last_row, last_addr;

    assign last_col  = (col_q  == CW'(NIB - 1));
    assign last_row  = (row_q  == RW'(ROWS - 1));
    assign last_addr = (addr_q == AW'(WORDS - 1));

    assign rd_en     = (state_q == ST_SHIFT_LO) && phase0;
    assign rd_addr   = addr_q;
    assign shift_clk = (state_q == ST_SHIFT_HI);
    assign row_latch = (state_q == ST_LATCH);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_SHIFT_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                ST_SHIFT_LO: state_d = ST_SHIFT_HI;                          // T_RISE
                ST_SHIFT_HI: state_d = last_col ? ST_LATCH : ST_SHIFT_LO;    // T_ROW_END / T_NEXT_COL
                ST_LATCH:    state_d = ST_HOLD;                              // T_LATCH_DROP
                ST_HOLD:     state_d = ST_SHIFT_LO;                          // T_NEXT_ROW
                default:     state_d = ST_SHIFT_LO;
            endcase
        end
    end

    // Outputs and datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            col_q      <= '0;
            row_q      <= '0;
            addr_q     <= '0;
            pix_nib    <= '0;
            frame_mark <= 1'b0;
            polarity   <= 1'b0;
        end else begin
            if (rd_en) begin
                addr_q <= last_addr ? '0 : addr_q + 1'b1;
            end
            if (tick) begin
                unique case (state_q)
                    ST_SHIFT_LO: pix_nib <= rd_data;
                    ST_SHIFT_HI: begin
                        if (!last_col) begin
                            col_q <= col_q + 1'b1;
                        end else if (row_q == '0) begin
                            frame_mark <= 1'b1;
                            polarity   <= ~polarity;
                        end
                    end
                    ST_LATCH: begin
                    end
                    ST_HOLD: begin
                        frame_mark <= 1'b0;
                        col_q      <= '0;
                        row_q      <= last_row ? '0 : row_q + 1'b1;
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    // R4: column clock idle while the row latch is high
    p_clk_idle_r4: assert property (@(posedge clk) disable iff (rst)
        row_latch |-> !shift_clk);

    // R2: data held across the sampling edge
    p_data_hold_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(shift_clk) |-> $stable(pix_nib));

    // R6: polarity only moves together with the frame marker rising
    p_pol_with_mark_r6: assert property (@(posedge clk) disable iff (rst)
        (polarity != $past(polarity)) |-> $rose(frame_mark));

    // R5: marker only ever rises with the row latch
    p_mark_on_latch_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_mark) |-> row_latch);

    // R8: the first fetch of a frame reads word 0
    p_addr_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && row_q == '0 && col_q == '0) |-> (addr_q == '0));

endmodule

// File: rtl/lcd_refresh_ctrl.sv
module lcd_refresh_ctrl #(
    parameter int WIDTH       = 64,
    parameter int HEIGHT      = 32,
    parameter int CLK_DIV     = 25,
    parameter int ARM_TOGGLES = 2,
    localparam int NIB   = WIDTH / 4,
    localparam int WORDS = NIB * HEIGHT,
    localparam int AW    = lcdt_pkg::safe_clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr_en,
    input  logic [AW-1:0] host_wr_addr,
    input  logic [3:0]    host_wr_data,
    output logic          host_wr_busy,
    output logic [3:0]    lcd_data,
    output logic          lcd_shift_clk,
    output logic          lcd_row_latch,
    output logic          lcd_frame_mark,
    output logic          lcd_polarity,
    output logic          lcd_drive_en
);

    generate
        if (CLK_DIV < 2 || (WIDTH % 4) != 0 || WIDTH < 8 || HEIGHT < 2 || ARM_TOGGLES < 1) begin : g_bad_cfg
            $error("lcd_refresh_ctrl: unsupported geometry or divider");
        end
    endgenerate

    logic          tick, phase0;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [3:0]    rd_data;

    lcdt_tick #(.DIV(CLK_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .phase0 (phase0)
    );

    lcdt_fb #(.DEPTH(WORDS)) u_fb (
        .clk     (clk),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (host_wr_en),
        .wr_addr (host_wr_addr),
        .wr_data (host_wr_data)
    );

    lcdt_seq #(.NIB(NIB), .ROWS(HEIGHT)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .phase0     (phase0),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .pix_nib    (lcd_data),
        .shift_clk  (lcd_shift_clk),
        .row_latch  (lcd_row_latch),
        .frame_mark (lcd_frame_mark),
        .polarity   (lcd_polarity)
    );

    lcdt_polguard #(.ARM(ARM_TOGGLES)) u_guard (
        .clk      (clk),
        .rst      (rst),
        .pol_in   (lcd_polarity),
        .drive_en (lcd_drive_en)
    );

    assign host_wr_busy = rd_en;

    // R9: the stall window sits in the low phase of the column clock
    p_busy_low_phase_r9: assert property (@(posedge clk) disable iff (rst)
        host_wr_busy |-> (!lcd_shift_clk && !lcd_row_latch));

    // R7: no bias enable while polarity has never left its reset value
    p_no_bias_early_r7: assert property (@(posedge clk) disable iff (rst)
        lcd_drive_en |-> $past(lcd_drive_en) || $past(lcd_polarity) != $past(lcd_polarity, 2));

endmodule

// File: tb/lcd_refresh_ctrl_bench.sv
module lcd_refresh_ctrl_bench;

    localparam int W     = 16;
    localparam int H     = 4;
    localparam int DIV   = 2;
    localparam int ARM   = 2;
    localparam int NIB   = W / 4;
    localparam int WORDS = NIB * H;
    localparam int AW    = $clog2(WORDS);
    localparam int ROWP  = (2 * NIB + 2) * DIV;
    localparam int NVEC  = 4;
    // {base[7:4], step[3:0]}: word a holds base + a*step (mod 16)
    localparam logic [7:0] VEC [NVEC] = '{8'h01, 8'hF0, 8'hA0, 8'h37};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_wr_en = 1'b0;
    logic [AW-1:0] host_wr_addr = '0;
    logic [3:0]    host_wr_data = '0;
    logic          host_wr_busy;
    logic [3:0]    lcd_data;
    logic          lcd_shift_clk, lcd_row_latch, lcd_frame_mark, lcd_polarity, lcd_drive_en;

    always #5 clk = ~clk;   // 10 ns period, 100 MHz

    lcd_refresh_ctrl #(.WIDTH(W), .HEIGHT(H), .CLK_DIV(DIV), .ARM_TOGGLES(ARM)) u_lcd_refresh_ctrl (
        .clk            (clk),
        .rst            (rst),
        .host_wr_en     (host_wr_en),
        .host_wr_addr   (host_wr_addr),
        .host_wr_data   (host_wr_data),
        .host_wr_busy   (host_wr_busy),
        .lcd_data       (lcd_data),
        .lcd_shift_clk  (lcd_shift_clk),
        .lcd_row_latch  (lcd_row_latch),
        .lcd_frame_mark (lcd_frame_mark),
        .lcd_polarity   (lcd_polarity),
        .lcd_drive_en   (lcd_drive_en)
    );

    int checks = 0, fails = 0, mchecks = 0, mfails = 0, stalls = 0;

    function automatic logic [3:0] pat(input logic [7:0] v, input int a);
        return v[7:4] + 4'(a) * v[3:0];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic mchk(input bit ok, input string req, input int act, input int exp);
        mchecks++;
        if (!ok) begin
            mfails++;
            $display("FAIL %s actual=%0d expected=%0d (monitor)", req, act, exp);
        end
    endtask

    // ---------------- pin monitor ----------------
    logic [3:0] got [WORDS];
    logic [3:0] line [NIB];
    int frames = 0;
    int cyc = 0, last_rise = -1, bcol = 0, brow = 0, rows_since = 0, toggles = 0, armed_at = 0;
    bit synced = 0;
    logic p_sc = 0, p_rl = 0, p_fm = 0, p_pol = 0;
    logic [3:0] held = '0;

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            last_rise = -1; bcol = 0; brow = 0; rows_since = 0; toggles = 0;
            synced = 0; p_sc = 0; p_rl = 0; p_fm = 0; p_pol = 0;
        end else begin
            if (lcd_shift_clk && !p_sc) held = lcd_data;
            if (!lcd_shift_clk && p_sc) begin
                mchk(lcd_data == held, "R2 data stable at sample edge", lcd_data, held);
                if (bcol < NIB) line[bcol] = lcd_data;
                bcol++;
            end
            if (lcd_row_latch) mchk(!lcd_shift_clk, "R4 shift clk idle in latch", lcd_shift_clk, 0);
            if (lcd_row_latch && !p_rl) begin
                mchk(bcol == NIB, "R3 pulses per row", bcol, NIB);
                if (last_rise >= 0) mchk(cyc - last_rise == ROWP, "R3 row period", cyc - last_rise, ROWP);
                last_rise = cyc;
            end
            if (!lcd_row_latch && p_rl) begin
                int r;
                r = lcd_frame_mark ? 0 : brow;
                if ((synced || lcd_frame_mark) && r < H)
                    for (int c = 0; c < NIB; c++) got[r*NIB + c] = line[c];
                if (lcd_frame_mark) begin
                    if (synced) mchk(rows_since == H, "R5 rows between frame marks", rows_since, H);
                    synced = 1; rows_since = 1; frames++;
                end else begin
                    rows_since++;
                end
                brow = r + 1; bcol = 0;
            end
            if (lcd_polarity != p_pol) begin
                mchk(lcd_frame_mark && !p_fm, "R6 polarity flips with mark rise", lcd_frame_mark, 1);
                toggles++;
                if (toggles == ARM) armed_at = cyc;
            end
            if (lcd_drive_en) mchk(toggles >= ARM, "R7 bias enable too early", toggles, ARM);
            if (toggles >= ARM && cyc - armed_at >= 2)
                mchk(lcd_drive_en, "R7 bias enable after arming", lcd_drive_en, 1);
            p_sc = lcd_shift_clk; p_rl = lcd_row_latch; p_fm = lcd_frame_mark; p_pol = lcd_polarity;
        end
    end

    // ---------------- host write ----------------
    task automatic host_write(input int a, input logic [3:0] d);
        bit acc = 0;
        host_wr_en = 1'b1; host_wr_addr = AW'(a); host_wr_data = d;
        while (!acc) begin
            acc = !host_wr_busy;
            if (!acc) stalls++;
            @(negedge clk);
        end
        host_wr_en = 1'b0;
    endtask

    task automatic compare_frame(input logic [7:0] v, input string tag);
        for (int a = 0; a < WORDS; a++)
            chk(got[a] === pat(v, a), tag, got[a], pat(v, a));
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", checks + mchecks, fails + mfails);
        $finish;
    endtask

    initial begin
        #2000000;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", checks + mchecks + 1, fails + mfails + 1);
        $finish;
    end

    initial begin
        int f0, t0, busy_n;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(lcd_shift_clk == 0, "R1 shift clk in reset", lcd_shift_clk, 0);
        chk(lcd_row_latch == 0, "R1 row latch in reset", lcd_row_latch, 0);
        chk(lcd_frame_mark == 0, "R1 frame mark in reset", lcd_frame_mark, 0);
        chk(lcd_polarity == 0, "R1 polarity in reset", lcd_polarity, 0);
        chk(lcd_drive_en == 0, "R1 bias enable in reset", lcd_drive_en, 0);
        chk(lcd_data == 0, "R1 data in reset", lcd_data, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!lcd_row_latch && !lcd_drive_en && !lcd_polarity, "R1 first cycle after reset",
            {lcd_row_latch, lcd_drive_en, lcd_polarity}, 0);

        // Table-driven frames: R8 mapping, R9 stalled writes during refresh
        for (int v = 0; v < NVEC; v++) begin
            for (int a = 0; a < WORDS; a++) host_write(a, pat(VEC[v], a));
            f0 = frames;
            wait (frames >= f0 + 2);
            @(negedge clk);
            compare_frame(VEC[v], "R8 frame content");
        end
        chk(stalls > 0, "R9 writes stalled by display fetch", stalls, 1);
        chk(lcd_drive_en == 1, "R7 bias enabled after frames", lcd_drive_en, 1);

        // R9: exactly one busy cycle per shift period over one row window
        busy_n = 0;
        for (int i = 0; i < ROWP; i++) begin
            if (host_wr_busy) begin
                busy_n++;
                chk(!lcd_shift_clk && !lcd_row_latch, "R9 busy only in low phase", lcd_shift_clk, 0);
            end
            @(negedge clk);
        end
        chk(busy_n == NIB, "R9 busy cycles per row", busy_n, NIB);

        // R5/R6: frame period and polarity step across one frame
        while (!(lcd_frame_mark && !p_fm)) @(negedge clk);
        t0 = cyc;
        f0 = lcd_polarity;
        @(negedge clk);
        while (!(lcd_frame_mark && !p_fm)) @(negedge clk);
        chk(cyc - t0 == H * ROWP, "R5 frame period", cyc - t0, H * ROWP);
        chk(lcd_polarity != f0[0], "R6 polarity inverted per frame", lcd_polarity, !f0[0]);

        // Mid-run reset: R1 again, R7 re-arms, R8 restart at word 0 over kept contents
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk(lcd_polarity == 0 && lcd_drive_en == 0, "R1 mid-run reset", {lcd_polarity, lcd_drive_en}, 0);
        chk(lcd_frame_mark == 0 && lcd_data == 0, "R1 mid-run reset outputs", {lcd_frame_mark, lcd_data}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(lcd_drive_en == 0, "R7 bias off right after reset", lcd_drive_en, 0);
        f0 = frames;
        wait (frames >= f0 + 1);
        @(negedge clk);
        chk(lcd_drive_en == 0, "R7 bias still off after one inversion", lcd_drive_en, 0);
        wait (frames >= f0 + 2);
        repeat (3) @(negedge clk);
        chk(lcd_drive_en == 1, "R7 bias on after second inversion", lcd_drive_en, 1);
        compare_frame(VEC[NVEC-1], "R8 content after reset");

        summary();
    end

endmodule